// File: doc/BRIEF.md
# Supply Rail Fault Status and Enable Controller

This block keeps the fault status and the enable control for one supervised supply rail. A host microcontroller sees it through a small register port. Four synchronized fault inputs feed it: current limit, overvoltage, undervoltage and overtemperature. A self-test completion pulse also feeds it, with a pass/fail qualifier. The block drives the rail enable, an active-low reset to the host and a driver-enable output.

The current-limit, undervoltage and overvoltage flags are live. They follow their conditions and clear by themselves, with no host read. Each one reads as 1 whenever the rail is disabled, because it is only meaningful while the rail is on. The self-test error flag is sticky. Only a passing self-test run clears it.

An overtemperature event has a stronger effect. It clears the enable bit and holds the controller in its reset state, with the reset and driver-enable outputs low. The rail stays off until the host writes the enable bit again. Reads never change state. Each read captures a coherent snapshot into a holding register.

Top module: `rail_fault_ctrl`

## Requirements
- R1: Status register (address 0) bit 7 is the current-limit flag. While the rail is enabled it equals the live current-limit input, and it returns to 0 as soon as the input drops, with no read needed.
- R2: While the rail is enabled, status bit 5 equals the live overvoltage input and status bit 6 equals the live undervoltage input.
- R3: While the rail enable is 0, status bits 7, 6 and 5 all read as 1, whatever the fault inputs are.
- R4: Overtemperature clears the rail enable on the next clock edge. It also places the controller in its reset state, in which `host_rst_n` and `drv_en` are both 0. Status bit 4 shows the live overtemperature input.
- R5: The rail enable changes to 1 only when the host writes control register (address 1) with bit 0 set while overtemperature is absent. It stays 0 after overtemperature clears until such a write arrives.
- R6: The controller leaves the reset state, driving `host_rst_n` and `drv_en` to 1, in two cases. The first is a control write with bit 1 set. The second is RELEASE_CYC consecutive clock edges without overtemperature. It never leaves while overtemperature is asserted.
- R7: Status bit 0 is the self-test error flag. It is 1 after power-on reset and is set by a failed self-test completion. Only a passing completion clears it.
- R8: A read captures the addressed register into `reg_rdata` on the clock edge of the read strobe. The value holds until the next read, and reading clears no flag.
- R9: After power-on reset the rail enable is 0, the self-test error flag is 1, and `host_rst_n` and `drv_en` are 0.
- R10: Reading the control register returns the rail enable in bit 0 and zeros elsewhere. Other addresses read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| flt_ilim | input | 1 | Current-limit condition, synchronized |
| flt_ov | input | 1 | Overvoltage condition, synchronized |
| flt_uv | input | 1 | Undervoltage condition, synchronized |
| flt_ot | input | 1 | Overtemperature condition, synchronized |
| bist_done | input | 1 | Self-test completion pulse |
| bist_pass | input | 1 | Self-test result, valid with `bist_done` |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Captured read data |
| rail_en | output | 1 | Enable to the supervised rail |
| host_rst_n | output | 1 | Active-low reset to the host |
| drv_en | output | 1 | Driver enable, low in the reset state |

## Verification
The assertions check four rules on every cycle. Overtemperature must drop the enable and force the reset state on the next edge. It must also hold that state while it persists. A rising enable must trace back to a host write, the self-test flag may fall only on a passing completion, and read data may change only on a read strobe. Only the bench scenarios can show the exact bit placement of each flag and the forced-1 reading while disabled. The same holds for the exact count of the timed release, and for the fact that the enable stays off after a timed release until the host writes it.

// File: rtl/rail_fault_pkg.sv
package rail_fault_pkg;

    localparam int REG_W     = 8;
    localparam int ADDR_STAT = 0;
    localparam int ADDR_CTRL = 1;

    // control register bit positions
    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_REL_BIT = 1;

    typedef enum logic {
        SEQ_RESET = 1'b0,
        SEQ_RUN   = 1'b1
    } seq_state_t;

    typedef struct packed {
        logic       ilim;   // bit 7
        logic       uv;     // bit 6
        logic       ov;     // bit 5
        logic       ot;     // bit 4
        logic [2:0] rsvd;   // bits 3..1
        logic       st_err; // bit 0
    } status_t;

    // live flags are only meaningful with the rail on; report 1 otherwise
    function automatic status_t build_status(
        input logic en,
        input logic ilim,
        input logic uv,
        input logic ov,
        input logic ot,
        input logic st_err
    );
        status_t s;
        s.ilim   = ilim | ~en;
        s.uv     = uv   | ~en;
        s.ov     = ov   | ~en;
        s.ot     = ot;
        s.rsvd   = 3'b000;
        s.st_err = st_err;
        return s;
    endfunction

endpackage

// File: rtl/rail_enable.sv
module rail_enable (
    input  logic clk,
    input  logic rst,
    input  logic ot,
    input  logic wr_ctrl,
    input  logic wr_en_val,
    output logic en_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b0;
        end else if (ot) begin
            en_q <= 1'b0;
        end else if (wr_ctrl) begin
            en_q <= wr_en_val;
        end
    end

    // R4
    ot_clears_en_chk: assert property (@(posedge clk) disable iff (rst)
        ot |=> !en_q);

    // R5
    en_rise_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(en_q) |-> $past(wr_ctrl && wr_en_val && !ot));
endmodule

// File: rtl/selftest_flag.sv
module selftest_flag (
    input  logic clk,
    input  logic rst,
    input  logic done,
    input  logic pass,
    output logic err_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b1;
        end else if (done) begin
            err_q <= ~pass;
        end
    end

    // R7
    err_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(err_q) |-> $past(done && pass));
endmodule

// File: rtl/rail_seq.sv
module rail_seq
    import rail_fault_pkg::*;
#(
    parameter int RELEASE_CYC = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ot,
    input  logic       rel_req,
    output seq_state_t state_q,
    output logic       host_rst_n,
    output logic       drv_en
);
    localparam int CNT_W = $clog2(RELEASE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RELEASE_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_RESET;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                SEQ_RUN: begin
                    cnt_q <= '0;
                    if (ot) state_q <= SEQ_RESET;
                end
                SEQ_RESET: begin
                    if (ot) begin
                        cnt_q <= '0;
                    end else if (rel_req || cnt_q == CNT_LAST) begin
                        state_q <= SEQ_RUN;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= SEQ_RESET;
            endcase
        end
    end

    assign host_rst_n = (state_q == SEQ_RUN);
    assign drv_en     = (state_q == SEQ_RUN);

    // R4
    ot_forces_reset_chk: assert property (@(posedge clk) disable iff (rst)
        ot |=> (!host_rst_n && !drv_en));

    // R6
    no_release_under_ot_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_RESET && ot) |=> state_q == SEQ_RESET);
endmodule

// File: rtl/stat_snapshot.sv
module stat_snapshot
    import rail_fault_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rd,
    input  logic             sel_stat,
    input  logic             sel_ctrl,
    input  status_t          stat,
    input  logic [REG_W-1:0] ctrl,
    output logic [REG_W-1:0] rdata_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (rd) begin
            if (sel_stat)      rdata_q <= stat;
            else if (sel_ctrl) rdata_q <= ctrl;
            else               rdata_q <= '0;
        end
    end

    // R8
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd |=> $stable(rdata_q));
endmodule

// File: rtl/rail_fault_ctrl.sv
module rail_fault_ctrl
    import rail_fault_pkg::*;
#(
    parameter int ADDR_W      = 2,
    parameter int RELEASE_CYC = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flt_ilim,
    input  logic              flt_ov,
    input  logic              flt_uv,
    input  logic              flt_ot,
    input  logic              bist_done,
    input  logic              bist_pass,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              rail_en,
    output logic              host_rst_n,
    output logic              drv_en
);
    logic       sel_stat, sel_ctrl, wr_ctrl, rel_req;
    logic       en_q, st_err_q;
    seq_state_t state_q;
    status_t    stat;
    logic [REG_W-1:0] ctrl_rd;

    assign sel_stat = (reg_addr == ADDR_W'(ADDR_STAT));
    assign sel_ctrl = (reg_addr == ADDR_W'(ADDR_CTRL));
    assign wr_ctrl  = reg_wr && sel_ctrl;
    assign rel_req  = wr_ctrl && reg_wdata[CTRL_REL_BIT];

    rail_enable u_en (
        .clk       (clk),
        .rst       (rst),
        .ot        (flt_ot),
        .wr_ctrl   (wr_ctrl),
        .wr_en_val (reg_wdata[CTRL_EN_BIT]),
        .en_q      (en_q)
    );

    selftest_flag u_bist (
        .clk   (clk),
        .rst   (rst),
        .done  (bist_done),
        .pass  (bist_pass),
        .err_q (st_err_q)
    );

    rail_seq #(.RELEASE_CYC(RELEASE_CYC)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .ot         (flt_ot),
        .rel_req    (rel_req),
        .state_q    (state_q),
        .host_rst_n (host_rst_n),
        .drv_en     (drv_en)
    );

    always_comb begin
        stat    = build_status(en_q, flt_ilim, flt_uv, flt_ov, flt_ot, st_err_q);
        ctrl_rd = '0;
        ctrl_rd[CTRL_EN_BIT] = en_q;
    end

    stat_snapshot u_snap (
        .clk      (clk),
        .rst      (rst),
        .rd       (reg_rd),
        .sel_stat (sel_stat),
        .sel_ctrl (sel_ctrl),
        .stat     (stat),
        .ctrl     (ctrl_rd),
        .rdata_q  (reg_rdata)
    );

    assign rail_en = en_q;

    // R4
    run_implies_no_ot_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_RUN) |-> !$past(flt_ot));
endmodule

// File: tb/rail_fault_ctrl_test.sv
module rail_fault_ctrl_test;
    localparam int REL = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic flt_ilim = 0, flt_ov = 0, flt_uv = 0, flt_ot = 0;
    logic bist_done = 0, bist_pass = 0;
    logic reg_wr = 0, reg_rd = 0;
    logic [1:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic rail_en, host_rst_n, drv_en;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] rv;

    always #2 clk = ~clk;

    rail_fault_ctrl #(.ADDR_W(2), .RELEASE_CYC(REL)) uut (
        .clk(clk), .rst(rst),
        .flt_ilim(flt_ilim), .flt_ov(flt_ov), .flt_uv(flt_uv), .flt_ot(flt_ot),
        .bist_done(bist_done), .bist_pass(bist_pass),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rail_en(rail_en), .host_rst_n(host_rst_n), .drv_en(drv_en)
    );

    // {ilim, ov, uv, expected status} with rail on, self-test flag clear
    localparam logic [10:0] VEC [6] = '{
        {3'b000, 8'h00}, {3'b100, 8'h80}, {3'b010, 8'h20},
        {3'b001, 8'h40}, {3'b110, 8'hA0}, {3'b111, 8'hE0}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_rd = 1; reg_addr = a;
        tick();
        reg_rd = 0;
        d = reg_rdata;
    endtask

    task automatic outs(input string tag, input logic en, input logic rn, input logic de);
        chk({tag, " rail_en"}, {7'b0, rail_en}, {7'b0, en});
        chk({tag, " host_rst_n"}, {7'b0, host_rst_n}, {7'b0, rn});
        chk({tag, " drv_en"}, {7'b0, drv_en}, {7'b0, de});
    endtask

    initial begin
        #(4 * 100000);
        n_fail++; n_checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 0;
        outs("R9 por", 0, 0, 0);
        rd(0, rv); chk("R9 R3 por status", rv, 8'hE1);
        rd(1, rv); chk("R10 por ctrl", rv, 8'h00);
        repeat (REL - 3) tick();
        chk("R6 timed release not early", {7'b0, host_rst_n}, 8'h00);
        tick();
        outs("R6 timed release", 0, 1, 1);

        bist_done = 1; bist_pass = 1; tick(); bist_done = 0;
        rd(0, rv); chk("R7 pass clears / R3 disabled", rv, 8'hE0);
        wr(1, 8'h01);
        chk("R5 host write enables", {7'b0, rail_en}, 8'h01);
        rd(1, rv); chk("R10 ctrl readback", rv, 8'h01);

        foreach (VEC[i]) begin
            {flt_ilim, flt_ov, flt_uv} = VEC[i][10:8];
            rd(0, rv);
            chk($sformatf("R1 R2 vector %0d", i), rv, VEC[i][7:0]);
        end
        flt_ilim = 0; flt_ov = 0; flt_uv = 0;

        flt_ilim = 1; rd(0, rv); chk("R1 ilim set", rv, 8'h80);
        flt_ilim = 0; repeat (3) tick();
        chk("R8 rdata holds without read", reg_rdata, 8'h80);
        rd(0, rv); chk("R1 ilim self-clears", rv, 8'h00);
        rd(0, rv); chk("R8 reread unchanged", rv, 8'h00);
        rd(2, rv); chk("R10 unused addr reads 0", rv, 8'h00);
        wr(2, 8'h00); chk("R10 unused addr write ignored", {7'b0, rail_en}, 8'h01);

        wr(1, 8'h00);
        rd(0, rv); chk("R3 disabled forces 1", rv, 8'hE0);
        flt_ov = 1; flt_ilim = 1;
        rd(0, rv); chk("R3 disabled with faults", rv, 8'hE0);
        flt_ov = 0; flt_ilim = 0;
        wr(1, 8'h01);

        flt_ot = 1; tick();
        outs("R4 ot entry", 0, 0, 0);
        rd(0, rv); chk("R4 ot status", rv, 8'hF0);
        wr(1, 8'h03);
        outs("R6 R5 write ignored under ot", 0, 0, 0);
        repeat (REL + 2) tick();
        chk("R6 no timed release under ot", {7'b0, host_rst_n}, 8'h00);
        flt_ot = 0;
        repeat (REL - 1) tick();
        chk("R6 ot cleared not early", {7'b0, host_rst_n}, 8'h00);
        tick();
        outs("R6 R5 timed release keeps rail off", 0, 1, 1);
        repeat (5) tick();
        chk("R5 stays off", {7'b0, rail_en}, 8'h00);
        wr(1, 8'h01);
        chk("R5 re-enable", {7'b0, rail_en}, 8'h01);

        flt_ot = 1; tick(); flt_ot = 0;
        wr(1, 8'h03);
        outs("R6 host release", 1, 1, 1);

        bist_done = 1; bist_pass = 0; tick(); bist_done = 0;
        rd(0, rv); chk("R7 fail sets", rv, 8'h01);
        rd(0, rv); chk("R7 R8 read keeps sticky", rv, 8'h01);
        repeat (4) tick();
        rd(0, rv); chk("R7 sticky holds", rv, 8'h01);
        bist_done = 1; bist_pass = 1; tick(); bist_done = 0;
        rd(0, rv); chk("R7 pass clears", rv, 8'h00);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule